// File: doc/BRIEF.md
# Quad-Precision Round-to-Integral Unit

This block rounds a 128-bit binary floating-point value in the quad format to an integral value in the same format. The value arrives as a 64-bit high word and a 64-bit low word. The high word holds the sign in bit 63, the 15-bit biased exponent in bits 62:48 and the top 48 fraction bits; the low word holds the remaining 64 fraction bits. A 2-bit mode input selects the rounding direction. The encoding of that input is shared with the other arithmetic units of the chip.

The unit also reports an inexact flag. The flag is set when the integral result differs from the operand. The datapath splits on exponent range:

- Operands that are already integral, infinite or NaN pass through. A NaN is returned quieted.
- Operands with a fractional part at or above one go through one masked 128-bit add over the whole encoding. A carry out of the fraction moves up into the exponent.
- Nonzero operands below one collapse to a signed zero or a signed one.

The logic is combinational. A parameter adds one output register stage, and that stage is on by default.

Top module: `qri_round_int`

## Requirements
- R1: An operand with biased exponent of 0x406F or above that is not a NaN (this includes infinities) is returned bit-for-bit unchanged, with inexact 0.
- R2: A NaN (exponent 0x7FFF and nonzero fraction) is returned with bit 47 of the high word (the quiet bit) forced to 1 and every other bit unchanged, with inexact 0.
- R3: The mode input is encoded as 2'b00 nearest-even, 2'b01 toward zero, 2'b10 toward minus infinity and 2'b11 toward plus infinity. In nearest-even mode, an exact halfway case goes to the even integer.
- R4: In the directed modes, toward zero truncates the fraction. Toward minus infinity increases the magnitude of negative non-integers only. Toward plus infinity increases the magnitude of positive non-integers only.
- R5: For exponents 0x3FFF to 0x406E, the operand is rounded at fraction bit position 0x406F minus the exponent, counted from bit 0 of the low word. All bits below that position are zero in the result. A round-up that reaches the next power of two increments the exponent and leaves the fraction zero.
- R6: At exponent 0x402F, the least significant integer bit is bit 0 of the high word and the first discarded bit is bit 63 of the low word. Rounding is correct across this word boundary, including the ties-to-even case.
- R7: An operand whose exponent and fraction are both zero is returned unchanged with its sign, with inexact 0.
- R8: A nonzero operand with exponent below 0x3FFF keeps its sign. In nearest-even mode it becomes 1.0 (exponent 0x3FFF, fraction 0) when the exponent is 0x3FFE and the fraction is nonzero, and zero otherwise. In toward-zero mode it becomes zero. In toward-minus-infinity mode it becomes -1.0 if negative and +0 if positive. In toward-plus-infinity mode it becomes -0 if negative and +1.0 if positive.
- R9: For every non-NaN operand, inexact is 1 exactly when the result differs from the operand.
- R10: With the output register enabled (the default), results appear one clock after the operand, and an active-low asynchronous reset clears all outputs to zero. With the register disabled, the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_hi | input | 64 | Operand high word: sign, exponent, top fraction bits |
| src_lo | input | 64 | Operand low word: low fraction bits |
| rmode | input | 2 | Rounding direction select |
| res_hi | output | 64 | Result high word |
| res_lo | output | 64 | Result low word |
| inexact | output | 1 | Result differs from the operand |

## Verification
The hardest case to reach from the ports is a rounding carry that runs from the low word into the high word and then into the exponent. This takes an operand whose kept fraction bits are all ones, with the rounding position in the low word or exactly at the word boundary. Directed tests build such operands at exponents 0x402F and 0x406E, and also near 1.0, 2.0 and the largest value with a fraction. They cover the halfway tie pattern in every mode. A pseudo-random sweep then draws exponents around the three range boundaries. Every result is compared against a bench model that rounds through integer-part extraction instead of masks.

// File: rtl/qri_pkg.sv
package qri_pkg;
  localparam int WORD_W  = 64;
  localparam int EXP_W   = 15;
  localparam int FRAC_W  = 112;
  localparam int TOT_W   = 2 * WORD_W;
  localparam int HI_FRAC = FRAC_W - WORD_W;
  localparam logic [EXP_W-1:0] EXP_ONE  = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [EXP_W-1:0] EXP_HALF = EXP_ONE - 1'b1;
  localparam logic [EXP_W-1:0] EXP_INT  = EXP_ONE + EXP_W'(FRAC_W);
  localparam logic [EXP_W-1:0] EXP_MAX  = {EXP_W{1'b1}};
  localparam int SH_W = $clog2(FRAC_W + 1);

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_DOWN = 2'b10,
    RM_UP   = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    RNG_TINY,
    RNG_MASK,
    RNG_BIG
  } range_e;

  function automatic logic [SH_W-1:0] frac_drop(input logic [EXP_W-1:0] e);
    logic [EXP_W-1:0] d;
    d = EXP_INT - e;
    return d[SH_W-1:0];
  endfunction

  function automatic logic [TOT_W-1:0] below_mask(input logic [SH_W-1:0] n);
    return (TOT_W'(1) << n) - TOT_W'(1);
  endfunction

  function automatic logic [TOT_W-1:0] round_masked(
      input logic [TOT_W-1:0] v, input logic [SH_W-1:0] n,
      input rmode_e m, input logic neg);
    logic [TOT_W-1:0] rm, lastb, halfb, s;
    rm    = below_mask(n);
    lastb = TOT_W'(1) << n;
    halfb = lastb >> 1;
    if (m == RM_NEAR) begin
      s = v + halfb;
      if ((s & rm) == '0) s = s & ~lastb;
    end else if (m != RM_ZERO && (neg ^ (m == RM_UP))) begin
      s = v + rm;
    end else begin
      s = v;
    end
    return s & ~rm;
  endfunction
endpackage

// File: rtl/qri_classify.sv
module qri_classify
  import qri_pkg::*;
(
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  output range_e            rng,
  output logic              is_nan,
  output logic              is_zero
);
  logic [EXP_W-1:0] e;
  logic             frac_nz;

  assign e       = hi[WORD_W-2 -: EXP_W];
  assign frac_nz = (hi[HI_FRAC-1:0] != '0) || (lo != '0);
  assign is_nan  = (e == EXP_MAX) && frac_nz;
  assign is_zero = (e == '0) && !frac_nz;

  always_comb begin
    if (e < EXP_ONE)       rng = RNG_TINY;
    else if (e < EXP_INT)  rng = RNG_MASK;
    else                   rng = RNG_BIG;
  end
endmodule

// File: rtl/qri_mask_round.sv
module qri_mask_round
  import qri_pkg::*;
(
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  input  rmode_e            mode,
  output logic [WORD_W-1:0] out_hi,
  output logic [WORD_W-1:0] out_lo,
  output logic              lost,
  output logic [TOT_W-1:0]  drop_mask
);
  logic [SH_W-1:0]  n;
  logic [TOT_W-1:0] v, r;

  assign v         = {hi, lo};
  assign n         = frac_drop(hi[WORD_W-2 -: EXP_W]);
  assign drop_mask = below_mask(n);
  assign r         = round_masked(v, n, mode, hi[WORD_W-1]);
  assign out_hi    = r[TOT_W-1:WORD_W];
  assign out_lo    = r[WORD_W-1:0];
  assign lost      = (v & drop_mask) != '0;
endmodule

// File: rtl/qri_tiny_round.sv
module qri_tiny_round
  import qri_pkg::*;
(
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  input  rmode_e            mode,
  output logic [WORD_W-1:0] out_hi,
  output logic [WORD_W-1:0] out_lo,
  output logic              lost
);
  logic             neg, to_one, frac_nz;
  logic [EXP_W-1:0] e;

  assign neg     = hi[WORD_W-1];
  assign e       = hi[WORD_W-2 -: EXP_W];
  assign frac_nz = (hi[HI_FRAC-1:0] != '0) || (lo != '0);
  assign lost    = (e != '0) || frac_nz;

  always_comb begin
    unique case (mode)
      RM_NEAR: to_one = (e == EXP_HALF) && frac_nz;
      RM_DOWN: to_one = neg;
      RM_UP:   to_one = !neg;
      default: to_one = 1'b0;
    endcase
    out_lo = '0;
    out_hi = {neg, (to_one ? EXP_ONE : EXP_W'(0)), {HI_FRAC{1'b0}}};
    if (!lost) out_hi = hi;
  end
endmodule

// File: rtl/qri_round_int.sv
module qri_round_int
  import qri_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] src_hi,
  input  logic [WORD_W-1:0] src_lo,
  input  logic [1:0]        rmode,
  output logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] res_lo,
  output logic              inexact
);
  range_e            rng;
  rmode_e            mode;
  logic              is_nan, is_zero;
  logic [WORD_W-1:0] m_hi, m_lo, t_hi, t_lo;
  logic              m_lost, t_lost;
  logic [TOT_W-1:0]  drop_mask;
  logic [WORD_W-1:0] c_hi, c_lo;
  logic              c_inx;

  assign mode = rmode_e'(rmode);

  qri_classify u_cls (
    .hi(src_hi), .lo(src_lo), .rng(rng), .is_nan(is_nan), .is_zero(is_zero)
  );

  qri_mask_round u_mask (
    .hi(src_hi), .lo(src_lo), .mode(mode),
    .out_hi(m_hi), .out_lo(m_lo), .lost(m_lost), .drop_mask(drop_mask)
  );

  qri_tiny_round u_tiny (
    .hi(src_hi), .lo(src_lo), .mode(mode),
    .out_hi(t_hi), .out_lo(t_lo), .lost(t_lost)
  );

  always_comb begin
    c_hi  = src_hi;
    c_lo  = src_lo;
    c_inx = 1'b0;
    unique case (rng)
      RNG_TINY: begin c_hi = t_hi; c_lo = t_lo; c_inx = t_lost; end
      RNG_MASK: begin c_hi = m_hi; c_lo = m_lo; c_inx = m_lost; end
      default:  if (is_nan) c_hi[HI_FRAC-1] = 1'b1;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_hi  <= '0;
          res_lo  <= '0;
          inexact <= 1'b0;
        end else begin
          res_hi  <= c_hi;
          res_lo  <= c_lo;
          inexact <= c_inx;
        end
      end
      p_reg_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (res_hi == $past(c_hi) && res_lo == $past(c_lo) && inexact == $past(c_inx)));
    end else begin : g_comb
      assign res_hi  = c_hi;
      assign res_lo  = c_lo;
      assign inexact = c_inx;
    end
  endgenerate

  p_big_unchanged_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rng == RNG_BIG && !is_nan) |-> ({c_hi, c_lo} == {src_hi, src_lo} && !c_inx));

  p_nan_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_nan |-> (c_hi[HI_FRAC-1] && c_hi[WORD_W-2 -: EXP_W] == EXP_MAX && c_lo == src_lo && !c_inx));

  p_dropped_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rng == RNG_MASK) |-> (({c_hi, c_lo} & drop_mask) == '0 && c_hi[WORD_W-1] == src_hi[WORD_W-1]));

  p_zero_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_zero |-> ({c_hi, c_lo} == {src_hi, src_lo} && !c_inx));

  p_tiny_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rng == RNG_TINY && !is_zero) |-> (c_lo == '0 && c_hi[HI_FRAC-1:0] == '0 && c_inx &&
      (c_hi[WORD_W-2 -: EXP_W] == '0 || c_hi[WORD_W-2 -: EXP_W] == EXP_ONE)));

  p_flag_vs_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nan |-> (c_inx == ({c_hi, c_lo} != {src_hi, src_lo})));
endmodule

// File: tb/tb_qri_round_int.sv
module tb_qri_round_int;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_hi = '0, src_lo = '0;
  logic [1:0]  rmode = 2'b00;
  logic [63:0] res_hi, res_lo;
  logic        inexact;
  int n_chk = 0, n_bad = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #4 clk = ~clk;

  qri_round_int dut (
    .clk(clk), .rst_n(rst_n), .src_hi(src_hi), .src_lo(src_lo), .rmode(rmode),
    .res_hi(res_hi), .res_lo(res_lo), .inexact(inexact)
  );

  function automatic logic [63:0] mkhi(input logic s, input logic [14:0] e, input logic [47:0] f);
    return {s, e, f};
  endfunction

  // bench model: split significand into integer part and remainder
  function automatic logic [128:0] model(input logic [63:0] h, input logic [63:0] l, input logic [1:0] m);
    logic s; logic [14:0] e; logic [113:0] sig, ip, rem, hv, ns;
    logic inc, nz; int f; logic [63:0] oh, ol;
    s = h[63]; e = h[62:48];
    nz = (h[62:0] != 0) || (l != 0);
    if (e >= 15'h406F) begin
      oh = h;
      if (e == 15'h7FFF && (h[47:0] != 0 || l != 0)) oh[47] = 1'b1;
      return {oh, l, 1'b0};
    end
    if (e < 15'h3FFF) begin
      if (!nz) return {h, l, 1'b0};
      case (m)
        2'b00: inc = (e == 15'h3FFE) && (h[47:0] != 0 || l != 0);
        2'b10: inc = s;
        2'b11: inc = !s;
        default: inc = 1'b0;
      endcase
      return {s, (inc ? 15'h3FFF : 15'h0), 48'h0, 64'h0, 1'b1};
    end
    f   = 32'h406F - int'(e);
    sig = {2'b01, h[47:0], l};
    ip  = sig >> f;
    rem = sig & ((114'd1 << f) - 114'd1);
    hv  = 114'd1 << (f - 1);
    case (m)
      2'b00: inc = (rem > hv) || (rem == hv && ip[0]);
      2'b10: inc = s && rem != 0;
      2'b11: inc = !s && rem != 0;
      default: inc = 1'b0;
    endcase
    ns = (ip + 114'(inc)) << f;
    if (ns[113]) begin ns = ns >> 1; e = e + 15'd1; end
    oh = {s, e, ns[111:64]}; ol = ns[63:0];
    return {oh, ol, (rem != 0)};
  endfunction

  task automatic apply(input logic [63:0] h, input logic [63:0] l, input logic [1:0] m, input string req);
    logic [128:0] exp_v;
    @(negedge clk);
    src_hi = h; src_lo = l; rmode = m;
    exp_v = model(h, l, m);
    @(posedge clk); @(negedge clk);
    n_chk++;
    if ({res_hi, res_lo, inexact} !== exp_v) begin
      n_bad++;
      $display("FAIL %s: in=%h_%h mode=%0d got=%h_%h/%b exp=%h_%h/%b", req, h, l, m,
               res_hi, res_lo, inexact, exp_v[128:65], exp_v[64:1], exp_v[0]);
    end
  endtask

  task automatic t_reset;  // R10
    n_chk++;
    if (res_hi !== 0 || res_lo !== 0 || inexact !== 0) begin
      n_bad++;
      $display("FAIL R10 reset: got=%h_%h/%b exp=0_0/0", res_hi, res_lo, inexact);
    end
  endtask

  task automatic t_big;
    apply(mkhi(0, 15'h406F, 48'h1234), 64'h5, 2'b11, "R1 big exact");
    apply(mkhi(1, 15'h7FFF, 48'h0), 64'h0, 2'b00, "R1 infinity");
    apply(mkhi(0, 15'h7FFF, 48'h0), 64'h1, 2'b01, "R2 signaling nan");
    apply(mkhi(1, 15'h7FFF, 48'h8000_0000_0001), 64'h0, 2'b10, "R2 quiet nan");
  endtask

  task automatic t_ties;  // R3: 2.5 -> 2, 3.5 -> 4, -2.5 -> -2
    apply(mkhi(0, 15'h4000, 48'h4000_0000_0000), 64'h0, 2'b00, "R3 tie 2.5");
    apply(mkhi(0, 15'h4000, 48'hC000_0000_0000), 64'h0, 2'b00, "R3 tie 3.5");
    apply(mkhi(1, 15'h4000, 48'h4000_0000_0000), 64'h0, 2'b00, "R3 tie -2.5");
    apply(mkhi(0, 15'h3FFF, 48'h8000_0000_0000), 64'h1, 2'b00, "R3 above tie 1.5+");
  endtask

  task automatic t_directed;  // R4 on +-1.25
    for (int m = 1; m < 4; m++) begin
      apply(mkhi(0, 15'h3FFF, 48'h4000_0000_0000), 64'h0, 2'(m), "R4 +1.25");
      apply(mkhi(1, 15'h3FFF, 48'h4000_0000_0000), 64'h0, 2'(m), "R4 -1.25");
    end
  endtask

  task automatic t_carry;  // R5: exponent increment and low-word positions
    apply(mkhi(0, 15'h3FFF, 48'hFFFF_FFFF_FFFF), 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, "R5 carry to 2");
    apply(mkhi(1, 15'h406E, 48'hFFFF_FFFF_FFFF), 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, "R5 top carry");
    apply(mkhi(0, 15'h406E, 48'h0), 64'h1, 2'b00, "R5 exp 406E tie");
    apply(mkhi(0, 15'h4040, 48'hABCD), 64'h0123_4567_89AB_CDEF, 2'b00, "R5 low mask");
    apply(mkhi(0, 15'h4040, 48'hABCD), 64'h0123_4567_89AB_CDEF, 2'b01, "R5 low trunc");
  endtask

  task automatic t_boundary;  // R6 exponent 0x402F
    apply(mkhi(0, 15'h402F, 48'h2), 64'h8000_0000_0000_0000, 2'b00, "R6 tie even");
    apply(mkhi(0, 15'h402F, 48'h3), 64'h8000_0000_0000_0000, 2'b00, "R6 tie odd");
    apply(mkhi(0, 15'h402F, 48'h2), 64'h8000_0000_0000_0001, 2'b00, "R6 above tie");
    apply(mkhi(0, 15'h402F, 48'hFFFF_FFFF_FFFF), 64'h1, 2'b11, "R6 carry exp");
    apply(mkhi(1, 15'h402F, 48'h5), 64'h7FFF_FFFF_FFFF_FFFF, 2'b10, "R6 down");
  endtask

  task automatic t_tiny;  // R7, R8
    apply(64'h0, 64'h0, 2'b11, "R7 +0");
    apply(mkhi(1, 0, 0), 64'h0, 2'b10, "R7 -0");
    for (int m = 0; m < 4; m++) begin
      apply(mkhi(0, 15'h3FFE, 48'h0), 64'h0, 2'(m), "R8 +0.5");
      apply(mkhi(1, 15'h3FFE, 48'h0), 64'h1, 2'(m), "R8 -0.5+");
      apply(mkhi(0, 15'h0, 48'h0), 64'h1, 2'(m), "R8 subnormal");
    end
    apply(mkhi(1, 15'h3FFD, 48'hFFFF_FFFF_FFFF), 64'hF, 2'b00, "R8 near 0.5");
  endtask

  task automatic t_sweep;  // R9 over pseudo-random operands
    for (int i = 0; i < 400; i++) begin
      logic [63:0] h, l; logic [14:0] e;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      h = {lfsr, lfsr ^ 32'h5A5A_0F0F};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      l = {lfsr ^ 32'h1357_9BDF, lfsr};
      e = 15'h3FF8 + 15'(lfsr[7:0] % 8'd128);
      if (lfsr[9:8] == 2'b00) e = 15'h402F;
      h[62:48] = e;
      if (lfsr[12]) l[30:0] = '0;
      apply(h, l, lfsr[11:10], "R9 sweep");
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_big();
    t_ties();
    t_directed();
    t_carry();
    t_boundary();
    t_tiny();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule